// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit

This block is the purely combinational datapath of a small accumulator machine. Each cycle the control logic presents a 3-bit operation code, the two halves of a 16-bit accumulator (low byte and high byte) and an 8-bit operand taken from the data register. The block returns the values both accumulator halves should take next. The surrounding CPU registers these values. That CPU also owns storage, memory access and instruction sequencing.

Most operations combine the low accumulator byte with the operand and write the result back to the low byte. Multiply is the exception: it spreads its double-width product across both halves. The parity operation works on the low byte alone. It replaces the top bit so that the full byte has even parity. Clear zeroes the low byte. Halt passes both halves through untouched. All operands are unsigned. A divide by zero is trapped: the low byte is kept, and a flag tells the control logic what happened.

Top module: `acc_alu`

## Requirements
- R1: The op code values are 3'b000 halt, 3'b001 add, 3'b010 multiply, 3'b011 divide, 3'b100 xor, 3'b101 parity, 3'b110 nand and 3'b111 clear. Under halt, both next halves equal the current halves.
- R2: Add sets the next low byte to (low + operand) mod 256 and drops the carry. The high byte passes through.
- R3: Multiply forms the unsigned 16-bit product of low and operand. The upper byte goes to the next high half and the lower byte goes to the next low half.
- R4: Divide with a non-zero operand sets the next low byte to the unsigned integer quotient low / operand, truncated. The high byte passes through.
- R5: Divide with a zero operand leaves both halves unchanged and drives div_by_zero to 1. For any other combination of op code and operand, div_by_zero is 0.
- R6: Xor sets the next low byte to low XOR operand. The high byte passes through.
- R7: Nand sets the next low byte to NOT(low AND operand). The high byte passes through.
- R8: Parity keeps bits 6..0 of the low byte and sets bit 7 to the XOR of bits 6..0, so the next low byte has an even number of ones. It ignores the operand, and the high byte passes through.
- R9: Clear sets the next low byte to zero and passes the high byte through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 3 | Operation code |
| acc_lo | input | 8 | Current low accumulator byte |
| acc_hi | input | 8 | Current high accumulator byte |
| operand | input | 8 | Operand from the data register |
| nxt_lo | output | 8 | Next low accumulator byte |
| nxt_hi | output | 8 | Next high accumulator byte |
| div_by_zero | output | 1 | Divide attempted with a zero operand |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between the inputs and any output. The bench applies a new op code, accumulator value and operand just after each rising clock edge. It compares all three outputs on the following falling edge against an integer model. By then the combinational paths have settled, and the next stimulus has not yet been applied. Directed vectors cover the boundaries: zero and all-ones operands, a divide by zero under every value of the low byte, the maximum product, and parity inputs with both odd and even weight. Random vectors over all op codes follow.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] acc_lo,
  input  logic [W-1:0] acc_hi,
  input  logic [W-1:0] operand,
  output logic [W-1:0] nxt_lo,
  output logic [W-1:0] nxt_hi,
  output logic         div_by_zero
);
  localparam logic [2:0] OP_HALT = 3'b000;
  localparam logic [2:0] OP_ADD  = 3'b001;
  localparam logic [2:0] OP_MUL  = 3'b010;
  localparam logic [2:0] OP_DIV  = 3'b011;
  localparam logic [2:0] OP_XOR  = 3'b100;
  localparam logic [2:0] OP_PAR  = 3'b101;
  localparam logic [2:0] OP_NAND = 3'b110;
  localparam logic [2:0] OP_CLR  = 3'b111;
  localparam int PW = 2 * W;

  logic [PW-1:0] prod;
  logic [W-1:0]  diff;
  logic [PW-1:0] back;
  logic          zero_opnd;

  assign zero_opnd = (operand == '0);
  assign prod = {{W{1'b0}}, acc_lo} * {{W{1'b0}}, operand};

  always_comb begin
    nxt_hi = acc_hi;
    nxt_lo = acc_lo;
    div_by_zero = 1'b0;
    case (op)
      OP_HALT: ;
      OP_ADD:  nxt_lo = acc_lo + operand;
      OP_MUL:  {nxt_hi, nxt_lo} = prod;
      OP_DIV:  if (zero_opnd) div_by_zero = 1'b1;
               else nxt_lo = acc_lo / operand;
      OP_XOR:  nxt_lo = acc_lo ^ operand;
      OP_PAR:  nxt_lo = {^acc_lo[W-2:0], acc_lo[W-2:0]};
      OP_NAND: nxt_lo = ~(acc_lo & operand);
      OP_CLR:  nxt_lo = '0;
      default: ;
    endcase

    diff = nxt_lo - acc_lo;
    back = {{W{1'b0}}, nxt_lo} * {{W{1'b0}}, operand};

    if (op == OP_HALT)
      a_r1_halt_hold: assert ({nxt_hi, nxt_lo} == {acc_hi, acc_lo});
    if (op != OP_MUL)
      a_r1_hi_hold: assert (nxt_hi == acc_hi);
    if (op == OP_ADD)
      a_r2_add_mod: assert (diff == operand);
    if (op == OP_MUL && zero_opnd)
      a_r3_mul_zero: assert (nxt_hi == '0 && nxt_lo == '0);
    if (op == OP_MUL && operand == W'(1))
      a_r3_mul_one: assert (nxt_hi == '0 && nxt_lo == acc_lo);
    if (op == OP_DIV && !zero_opnd) begin
      a_r4_quot_low: assert (back <= {{W{1'b0}}, acc_lo});
      a_r4_quot_high: assert ({{W{1'b0}}, acc_lo} - back < {{W{1'b0}}, operand});
    end
    if (op == OP_DIV && zero_opnd)
      a_r5_dz_hold: assert (div_by_zero && nxt_lo == acc_lo);
    if (div_by_zero)
      a_r5_dz_only_div: assert (op == OP_DIV && zero_opnd);
    if (op == OP_XOR)
      a_r6_xor_undo: assert ((nxt_lo ^ operand) == acc_lo);
    if (op == OP_NAND)
      a_r7_nand_inv: assert ((~nxt_lo) == (acc_lo & operand));
    if (op == OP_PAR)
      a_r8_even: assert ((^nxt_lo) == 1'b0 && nxt_lo[W-2:0] == acc_lo[W-2:0]);
    if (op == OP_CLR)
      a_r9_clear: assert (nxt_lo == '0);
  end
endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0] op = 3'b000;
  logic [7:0] acc_lo = 8'h00, acc_hi = 8'h00, operand = 8'h00;
  logic [7:0] nxt_lo, nxt_hi;
  logic div_by_zero;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  acc_alu uut (
    .op(op), .acc_lo(acc_lo), .acc_hi(acc_hi), .operand(operand),
    .nxt_lo(nxt_lo), .nxt_hi(nxt_hi), .div_by_zero(div_by_zero)
  );

  function automatic string tag_of(input logic [2:0] o, input logic [7:0] b);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return (b == 0) ? "R5" : "R4";
      3'd4: return "R6";
      3'd5: return "R8";
      3'd6: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [2:0] o, input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] b);
    int a, x, eh, el, ed, ones;
    @(posedge clk);
    op <= o; acc_lo <= lo; acc_hi <= hi; operand <= b;
    a = lo; x = b; eh = hi; el = lo; ed = 0;
    case (o)
      3'd1: el = (a + x) % 256;
      3'd2: begin eh = (a * x) / 256; el = (a * x) % 256; end
      3'd3: if (x == 0) ed = 1; else el = a / x;
      3'd4: el = a ^ x;
      3'd5: begin
        ones = 0;
        for (int i = 0; i < 7; i++) ones += (a >> i) & 1;
        el = (a % 128) + ((ones % 2) * 128);
      end
      3'd6: el = 255 - (a & x);
      3'd7: el = 0;
      default: ;
    endcase
    @(negedge clk);
    compared++;
    if (int'(nxt_lo) != el || int'(nxt_hi) != eh || int'(div_by_zero) != ed) begin
      mismatched++;
      $display("FAIL %s op=%0d lo=%02h hi=%02h b=%02h: got hi=%02h lo=%02h dz=%0d, want hi=%02h lo=%02h dz=%0d",
               tag_of(o, b), o, lo, hi, b, nxt_hi, nxt_lo, div_by_zero, eh, el, ed);
    end
  endtask

  initial begin
    @(negedge clk);
    compared++;
    if (nxt_lo !== 8'h00 || nxt_hi !== 8'h00 || div_by_zero !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 idle: got hi=%02h lo=%02h dz=%0d, want 00 00 0", nxt_hi, nxt_lo, div_by_zero);
    end
    apply(3'd0, 8'h5A, 8'hC3, 8'hFF);   // R1 halt
    apply(3'd1, 8'hFF, 8'h12, 8'h01);   // R2 wrap
    apply(3'd1, 8'h80, 8'h77, 8'h80);   // R2 wrap to zero
    apply(3'd2, 8'hFF, 8'h00, 8'hFF);   // R3 max product
    apply(3'd2, 8'h10, 8'hAB, 8'h10);   // R3 crosses into high
    apply(3'd2, 8'h9C, 8'h44, 8'h00);   // R3 zero
    apply(3'd3, 8'hFF, 8'h21, 8'h01);   // R4 by one
    apply(3'd3, 8'h07, 8'h21, 8'h08);   // R4 truncates to zero
    apply(3'd3, 8'h64, 8'h21, 8'h07);   // R4
    for (int v = 0; v < 256; v++)
      apply(3'd3, 8'(v), 8'hE5, 8'h00); // R5 every dividend
    apply(3'd4, 8'hF0, 8'h3C, 8'hFF);   // R6
    apply(3'd6, 8'hFF, 8'h3C, 8'hFF);   // R7 all ones
    apply(3'd6, 8'h00, 8'h3C, 8'h00);   // R7 all zeros
    apply(3'd5, 8'h01, 8'h99, 8'hAA);   // R8 odd weight sets bit 7
    apply(3'd5, 8'h83, 8'h99, 8'h55);   // R8 even weight clears bit 7
    apply(3'd5, 8'h7F, 8'h99, 8'h00);   // R8
    apply(3'd7, 8'hFF, 8'hBE, 8'hFF);   // R9
    for (int n = 0; n < 3000; n++)
      apply(3'($urandom), 8'($urandom), 8'($urandom), ((n % 5) == 0) ? 8'h00 : 8'($urandom));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got no completion, want completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule